// File: doc/BRIEF.md
# Interrupt flag and line router

This block gathers 32 one-cycle event pulses from the rest of a bus controller into sticky flag bits. Software reads the flags through a small word-addressed register port. It clears any set of them by writing ones to those bit positions. Writing back a value just read therefore clears exactly the flags that were seen and no others.

A per-bit mask register decides which flags may raise an interrupt. A per-bit route register sends each unmasked flag to one of two interrupt lines. A two-bit line-enable register gates each line on its own. Three summary outputs tell a service routine at a glance whether any error-state flag is set, any protocol-error flag is set, or any flag in the wider bus-error class is set. The summaries look at the raw flags, whatever the mask.

Top module: `irq_router`

## Requirements
- R1: An event pulse on `evt_i[k]` sets flag k on the next clock edge. The flag stays set until software clears it, whatever `evt_i` does afterwards.
- R2: A write to word address 0 clears every flag whose `wdata_i` bit is 1 and leaves the flags whose bit is 0 unchanged. Writing back a value just read from address 0 clears exactly those flags.
- R3: When an event and a clearing write reach the same bit in the same cycle, the flag ends up set.
- R4: A read of address 0 returns the raw flags, whatever the mask. Address 1 (mask), address 2 (route) and address 3 (line enable, in bits 1:0 with the upper bits read as zero) return the values last written. All reads are combinational from `addr_i`.
- R5: `irq_line_o[0]` is the OR over all bits of (flag AND mask AND route bit 0). `irq_line_o[1]` is the OR over all bits of (flag AND mask AND route bit 1). Each line is then ANDed with its own line-enable bit: bit 0 for line 0, bit 1 for line 1.
- R6: With a line-enable bit at 0, that line stays low. The flags are not cleared and still read back as set.
- R7: `grp_state_o` is high exactly when any of flags 25, 24 or 23 is set. These are bus-off, error-warning and error-passive.
- R8: `grp_proto_o` is high exactly when any of flags 31 to 27 is set. These are the stuff, form, ack, bit and CRC errors.
- R9: `grp_bus_o` is high exactly when any flag in the set {31..26, 22, 21, 20, 18, 17, 16, 15, 7, 3} is set (mask 0xFC778088). This set includes the message-lost flag 3 of receive queue 0. Flag 0 (new message), flag 9 (transmit complete) and the other receive-queue flags are not in it.
- R10: After a synchronous reset, all flags, the mask, the route and the line enable are zero, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | One-cycle event pulses, one per flag |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address: 0 flags, 1 mask, 2 route, 3 line enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_line_o | output | 2 | Interrupt lines 0 and 1 |
| grp_state_o | output | 1 | Any error-state flag set |
| grp_proto_o | output | 1 | Any protocol-error flag set |
| grp_bus_o | output | 1 | Any bus-error-class flag set |

## Verification
Each of the 32 flags is raised on its own and then tried with both route values and all four line-enable codes. Single-bit patterns show that every bit reaches the right line, that the wrong line stays quiet, and that each summary group holds exactly its own bits. A dense multi-bit pattern, with a mixed mask and a mixed route, shows the OR across bits and the masking working together. A partial write-back and a full write-back tell a clear of selected bits apart from a global clear. A clearing write that collides with an event on one bit, while clearing a neighbouring bit, separates event priority from the ordinary clear.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int N_FLAGS = 32;
    localparam int DATA_W  = 32;
    localparam int N_LINES = 2;
    localparam int ADDR_W  = 2;

    typedef logic [N_FLAGS-1:0] flag_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAG    = 2'd0,
        REG_MASK    = 2'd1,
        REG_ROUTE   = 2'd2,
        REG_LINE_EN = 2'd3
    } reg_sel_e;

    // Flag bit positions the group masks depend on
    localparam int BIT_BUS_OFF  = 25;
    localparam int BIT_WARN     = 24;
    localparam int BIT_PASSIVE  = 23;

    localparam flag_vec_t GRP_STATE_MASK = flag_vec_t'((1 << BIT_BUS_OFF) | (1 << BIT_WARN) | (1 << BIT_PASSIVE));
    localparam flag_vec_t GRP_PROTO_MASK = 32'hF800_0000;
    localparam flag_vec_t GRP_BUS_MASK   = 32'hFC77_8088;

    typedef struct packed {
        flag_vec_t           mask;
        flag_vec_t           route;
        logic [N_LINES-1:0]  line_en;
    } cfg_t;

    typedef struct packed {
        logic state;
        logic proto;
        logic bus;
    } grp_sum_t;

    function automatic logic any_hit(flag_vec_t f, flag_vec_t m);
        return |(f & m);
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_router_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t evt,
    input  flag_vec_t clr,
    output flag_vec_t flags
);
    flag_vec_t flag_q;

    // Event has priority over a clear of the same bit
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~clr) | evt;
    end

    assign flags = flag_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(addr))
                REG_MASK:    cfg_q.mask    <= wdata;
                REG_ROUTE:   cfg_q.route   <= wdata;
                REG_LINE_EN: cfg_q.line_en <= wdata[N_LINES-1:0];
                default:     cfg_q         <= cfg_q;
            endcase
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux
    import irq_router_pkg::*;
(
    input  flag_vec_t          flags,
    input  cfg_t               cfg,
    output logic [N_LINES-1:0] line
);
    flag_vec_t armed;
    assign armed = flags & cfg.mask;

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        flag_vec_t sel;
        if (l == 0) begin : g_zero
            assign sel = ~cfg.route;
        end else begin : g_one
            assign sel = cfg.route;
        end
        assign line[l] = any_hit(armed, sel) & cfg.line_en[l];
    end
endmodule

// File: rtl/irq_group_sum.sv
module irq_group_sum
    import irq_router_pkg::*;
(
    input  flag_vec_t flags,
    output grp_sum_t  sum
);
    always_comb begin
        sum.state = any_hit(flags, GRP_STATE_MASK);
        sum.proto = any_hit(flags, GRP_PROTO_MASK);
        sum.bus   = any_hit(flags, GRP_BUS_MASK);
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_FLAGS-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [N_LINES-1:0] irq_line_o,
    output logic               grp_state_o,
    output logic               grp_proto_o,
    output logic               grp_bus_o
);
    flag_vec_t flag_q;
    flag_vec_t clr_vec;
    cfg_t      cfg_q;
    grp_sum_t  grp;

    assign clr_vec = (wr_en_i && reg_sel_e'(addr_i) == REG_FLAG) ? wdata_i : '0;

    irq_flag_bank u_flags (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_i),
        .clr   (clr_vec),
        .flags (flag_q)
    );

    irq_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en_i),
        .addr  (addr_i),
        .wdata (wdata_i),
        .cfg   (cfg_q)
    );

    irq_line_mux u_mux (
        .flags (flag_q),
        .cfg   (cfg_q),
        .line  (irq_line_o)
    );

    irq_group_sum u_grp (
        .flags (flag_q),
        .sum   (grp)
    );

    assign grp_state_o = grp.state;
    assign grp_proto_o = grp.proto;
    assign grp_bus_o   = grp.bus;

    always_comb begin
        case (reg_sel_e'(addr_i))
            REG_FLAG:    rdata_o = flag_q;
            REG_MASK:    rdata_o = cfg_q.mask;
            REG_ROUTE:   rdata_o = cfg_q.route;
            REG_LINE_EN: rdata_o = {{(DATA_W-N_LINES){1'b0}}, cfg_q.line_en};
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [N_FLAGS-1:0] evt_i,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic [N_FLAGS-1:0] flags,
    input logic [N_LINES-1:0] line_en,
    input logic [N_LINES-1:0] irq_line_o,
    input logic               grp_state_o,
    input logic               grp_proto_o,
    input logic               grp_bus_o
);
    p_evt_sets_r1: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));

    p_flags_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && evt_i == '0) |=> $stable(flags));

    p_w1c_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 2'd0 && evt_i == '0) |=> (flags == ($past(flags) & ~$past(wdata_i))));

    p_event_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 2'd0 && (evt_i & wdata_i) != '0)
        |=> ((flags & $past(evt_i & wdata_i)) == $past(evt_i & wdata_i)));

    p_line0_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !line_en[0] |-> !irq_line_o[0]);

    p_line1_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !line_en[1] |-> !irq_line_o[1]);

    p_state_grp_r7: assert property (@(posedge clk) disable iff (rst)
        flags[24] |-> grp_state_o);

    p_proto_grp_r8: assert property (@(posedge clk) disable iff (rst)
        flags[29] |-> (grp_proto_o && grp_bus_o));

    p_bus_grp_r9: assert property (@(posedge clk) disable iff (rst)
        flags[3] |-> grp_bus_o);
endmodule

bind irq_router irq_router_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .flags       (flag_q),
    .line_en     (cfg_q.line_en),
    .irq_line_o  (irq_line_o),
    .grp_state_o (grp_state_o),
    .grp_proto_o (grp_proto_o),
    .grp_bus_o   (grp_bus_o)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [1:0]  irq_line_o;
    logic        grp_state_o, grp_proto_o, grp_bus_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model of the programmed state
    logic [31:0] m_flags = '0, m_mask = '0, m_route = '0;
    logic [1:0]  m_len = '0;

    localparam logic [31:0] STATE_M = 32'h0380_0000;
    localparam logic [31:0] PROTO_M = 32'hF800_0000;
    localparam logic [31:0] BUS_M   = 32'hFC77_8088;

    irq_router dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_line_o(irq_line_o),
        .grp_state_o(grp_state_o), .grp_proto_o(grp_proto_o), .grp_bus_o(grp_bus_o)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        tick();
        wr_en_i = 1'b0; wdata_i = '0;
        case (a)
            2'd0: m_flags = m_flags & ~d;
            2'd1: m_mask  = d;
            2'd2: m_route = d;
            default: m_len = d[1:0];
        endcase
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic pulse(logic [31:0] v);
        evt_i = v;
        tick();
        evt_i = '0;
        m_flags = m_flags | v;
    endtask

    function automatic logic [1:0] exp_lines();
        logic [31:0] a = m_flags & m_mask;
        return {(|(a & m_route)) & m_len[1], (|(a & ~m_route)) & m_len[0]};
    endfunction

    task automatic chk_outputs(string req_line);
        chk(req_line, {30'd0, irq_line_o}, {30'd0, exp_lines()});
        chk("R7 state group", {31'd0, grp_state_o}, {31'd0, |(m_flags & STATE_M)});
        chk("R8 proto group", {31'd0, grp_proto_o}, {31'd0, |(m_flags & PROTO_M)});
        chk("R9 bus group",   {31'd0, grp_bus_o},   {31'd0, |(m_flags & BUS_M)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // R10 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            chk("R10 reset register", r, 32'd0);
        end
        chk("R10 reset outputs", {27'd0, irq_line_o, grp_state_o, grp_proto_o, grp_bus_o}, 32'd0);

        // Sweep every flag over route and line-enable codes
        for (int k = 0; k < 32; k++) begin
            wr(2'd1, 32'd0);
            wr(2'd0, 32'hFFFF_FFFF);
            pulse(32'd1 << k);
            tick();
            tick();
            rd(2'd0, r);
            chk("R1 sticky single flag / R4 raw read with mask off", r, 32'd1 << k);
            wr(2'd3, 32'd3);
            chk_outputs("R5 masked flag reaches no line");
            wr(2'd1, 32'd1 << k);
            rd(2'd1, r);
            chk("R4 mask readback", r, 32'd1 << k);
            for (int rt = 0; rt < 2; rt++) begin
                wr(2'd2, rt[0] ? (32'd1 << k) : 32'd0);
                for (int le = 0; le < 4; le++) begin
                    wr(2'd3, 32'hFFFF_FFF0 | le);
                    rd(2'd3, r);
                    chk("R4 line enable readback", r, le);
                    chk_outputs("R5 R6 route and gate");
                end
            end
            rd(2'd0, r);
            chk("R6 flags kept while lines gated", r, 32'd1 << k);
        end

        // Dense pattern with mixed mask and route
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'h0F0F_F0F0);
        wr(2'd2, 32'h00FF_00FF);
        wr(2'd3, 32'd3);
        pulse(32'hA5A5_0F0F);
        chk_outputs("R5 dense pattern");
        rd(2'd0, r);
        chk("R1 dense flags", r, 32'hA5A5_0F0F);

        // R2 partial clear, then write back of a read value
        wr(2'd0, 32'h0000_0F00);
        rd(2'd0, r);
        chk("R2 partial clear", r, 32'hA5A5_000F);
        chk_outputs("R5 after partial clear");
        wr(2'd0, r);
        rd(2'd0, r);
        chk("R2 write back clears all seen", r, 32'd0);
        chk_outputs("R5 after full clear");

        // R3 event and clear on the same bit in the same cycle
        pulse(32'h0000_0060);
        evt_i = 32'h0000_0020;
        wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 32'h0000_0060;
        tick();
        wr_en_i = 1'b0; evt_i = '0; wdata_i = '0;
        m_flags = 32'h0000_0020;
        rd(2'd0, r);
        chk("R3 event wins over clear", r, 32'h0000_0020);

        // R1 stays set with no event, many cycles
        repeat (20) tick();
        rd(2'd0, r);
        chk("R1 still set", r, 32'h0000_0020);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule